// File: doc/BRIEF.md
# Start-Stop to Fixed-Clock Transmit Rate Converter

This block accepts a start-stop serial character stream from a terminal and re-times it onto a fixed output bit clock for a synchronous modulator path. The terminal's bit rate may be slightly above or below nominal. The output rate is set only by the output bit-tick enable, so the block never slips a bit. It absorbs the rate difference inside the character stream instead. When the terminal runs fast, a stop bit is dropped from an outgoing character. When the terminal runs slow, extra mark bits are sent between characters.

The serial input is sampled with a 16x oversampling enable. A start bit is confirmed at its middle, and data bits are taken at their centres. Received characters wait in a two-entry elastic buffer. A serializer re-frames them on each output bit tick. A bypass path sends the synchronized line straight to the output and adds nothing to the stream. This path serves handshaking and synchronous operation, and it is forced whenever the frequency-shift-keying mode is selected. The supported terminal rates are 600, 1200 and 2400 bit/s. The system picks the rate through the oversampling and bit-tick enables.

Top module: `async_sync_rate_conv`

## Requirements
- R1: While reset is high and on the first cycle after it, tx_bit is 1 and tx_valid is 0.
- R2: tx_valid is 1 exactly on the cycle after each cycle where bit_tick is 1, and 0 otherwise; tx_bit changes only together with such a strobe.
- R3: When no character is buffered at an output character boundary, the bit sent on that tick is a mark (1), i.e. a stop bit is inserted.
- R4: Each received character is re-sent as a start bit 0, its data bits LSB first, then a stop bit 1, with the data equal to the bits sampled at the input.
- R5: char_len selects the total character length including start and stop bits: 0 = 8, 1 = 9, 2 = 10, 3 = 11 (6 to 9 data bits); it is captured per character at the start bit.
- R6: When a character is taken from the buffer while the buffer holds at least HIGH_WATER (default 2) characters, its stop bit is omitted, so the next start bit directly follows its last data bit (limited by R7 and R8).
- R7: At most one stop bit is omitted in any 8 consecutive output characters; the first character after reset may lose its stop bit.
- R8: A character whose stop bit is sampled low (break) is re-sent with a low stop bit; neither that character nor the one after it ever has its stop bit omitted.
- R9: With bypass at 1, each bit_tick sends the synchronized line value unchanged, and no bit is ever inserted or deleted.
- R10: fsk_sel at 1 forces the bypass behaviour of R9 regardless of bypass.
- R11: Characters leave in arrival order and none is lost while the terminal stays within the deletion capacity; a character that arrives while the buffer is full and nothing is being taken is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Start-stop serial data from the terminal, idle high |
| os_tick | input | 1 | Input sampling enable at 16x the nominal bit rate |
| bit_tick | input | 1 | Output bit enable at the nominal bit rate |
| char_len | input | 2 | Character length select (R5) |
| bypass | input | 1 | Pass-through request |
| fsk_sel | input | 1 | Frequency-shift-keying mode, forces pass-through |
| tx_bit | output | 1 | Re-timed serial output bit |
| tx_valid | output | 1 | One-cycle strobe marking each new tx_bit |

## Verification
The receiver can write a character into the elastic buffer in the same cycle that the serializer takes the head character out and decides whether to drop its stop bit. The test provokes this by holding bit_tick off until two characters are queued. It then restarts the output slightly slower than the input while characters keep arriving back to back, so writes and reads land next to each other at a full buffer. The output stream is parsed independently: every character must appear in order with correct data, a dropped stop bit must occur, dropped stop bits must lie at least eight characters apart, and none may sit on or right after a break.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int MAX_DATA = 9;

  typedef struct packed {
    logic                brk;
    logic [1:0]          len;
    logic [MAX_DATA-1:0] data;
  } char_t;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd6 + {2'b00, len};
  endfunction
endpackage

// File: rtl/rc_rx_deser.sv
module rc_rx_deser
  import rc_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       os_tick,
  input  logic       rx_s,
  input  logic [1:0] len_sel,
  output logic       push,
  output char_t      push_char
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_HUNT, S_START, S_DATA, S_STOP, S_WAIT} st_t;

  st_t                 st;
  logic [CW-1:0]       cnt;
  logic [3:0]          idx;
  logic [1:0]          len_q;
  logic [MAX_DATA-1:0] dsh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st        <= S_HUNT;
      cnt       <= '0;
      idx       <= '0;
      len_q     <= '0;
      dsh       <= '0;
      push      <= 1'b0;
      push_char <= '0;
    end else begin
      push <= 1'b0;
      if (os_tick) begin
        case (st)
          S_HUNT: begin
            if (!rx_s) begin
              st    <= S_START;
              cnt   <= '0;
              len_q <= len_sel;
              dsh   <= '0;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              st  <= rx_s ? S_HUNT : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt      <= '0;
              dsh[idx] <= rx_s;
              idx      <= idx + 4'd1;
              if (idx == data_bits(len_q) - 4'd1) st <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt            <= '0;
              push           <= 1'b1;
              push_char.brk  <= !rx_s;
              push_char.len  <= len_q;
              push_char.data <= dsh;
              st             <= rx_s ? S_HUNT : S_WAIT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WAIT: begin
            if (rx_s) st <= S_HUNT;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rc_elastic_fifo.sv
module rc_elastic_fifo
  import rc_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  char_t         wdata,
  input  logic          pop,
  output char_t         rdata,
  output logic [CW-1:0] count,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  char_t         mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          wr_en, rd_en;

  assign empty = (count == '0);
  assign rd_en = pop && !empty;
  assign wr_en = push && ((count != CFULL) || rd_en);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst || clr)
    push |-> (count != CFULL) || pop) else $error("buffer overrun"); // R11
endmodule

// File: rtl/rc_tx_ser.sv
module rc_tx_ser
  import rc_pkg::*;
#(
  parameter int DEPTH      = 2,
  parameter int HIGH_WATER = 2,
  parameter int DEL_WINDOW = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bit_tick,
  input  logic          empty,
  input  logic [CW-1:0] count,
  input  char_t         head,
  output logic          pop,
  output logic          ser_bit,
  output logic          busy
);
  localparam int KW = $clog2(DEL_WINDOW);
  localparam logic [KW-1:0] KMAX = KW'(DEL_WINDOW - 1);
  localparam int QW = $clog2(DEL_WINDOW + 1);
  localparam logic [QW-1:0] QMAX = QW'(DEL_WINDOW);
  localparam logic [CW-1:0] HWM  = CW'(HIGH_WATER);

  logic [MAX_DATA:0]   sh;
  logic [MAX_DATA:0]   frame;
  logic [3:0]          rem;
  logic [3:0]          nd;
  logic [KW-1:0]       credit;
  logic                prev_brk;
  logic                drop_stop;

  always_comb begin
    nd        = data_bits(head.len);
    frame     = {1'b0, head.data};
    frame[nd] = !head.brk;
  end

  assign drop_stop = (count >= HWM) && (credit == KMAX) && !head.brk && !prev_brk;
  assign pop       = bit_tick && !clr && !busy && !empty;
  assign ser_bit   = busy ? sh[0] : empty;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh       <= '0;
      rem      <= '0;
      busy     <= 1'b0;
      credit   <= KMAX;
      prev_brk <= 1'b0;
    end else if (pop) begin
      sh       <= frame;
      rem      <= drop_stop ? nd : nd + 4'd1;
      busy     <= 1'b1;
      prev_brk <= head.brk;
      if (drop_stop)          credit <= '0;
      else if (credit != KMAX) credit <= credit + 1'b1;
    end else if (bit_tick && busy) begin
      sh  <= sh >> 1;
      rem <= rem - 4'd1;
      if (rem == 4'd1) busy <= 1'b0;
    end
  end

  // independent count of characters taken since the last shortened one
  logic [QW-1:0] chk_since;
  always_ff @(posedge clk) begin
    if (rst || clr) chk_since <= QMAX;
    else if (pop) begin
      if (drop_stop)            chk_since <= '0;
      else if (chk_since != QMAX) chk_since <= chk_since + 1'b1;
    end
  end

  AST_DEL_SPACING: assert property (@(posedge clk) disable iff (rst || clr)
    (pop && drop_stop) |-> (chk_since >= QW'(DEL_WINDOW - 1))) else $error("deletion too close"); // R7
  AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (rst || clr)
    pop |=> busy) else $error("pop without frame"); // R4
endmodule

// File: rtl/async_sync_rate_conv.sv
module async_sync_rate_conv
  import rc_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DEPTH      = 2,
  parameter int HIGH_WATER = 2,
  parameter int DEL_WINDOW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_serial,
  input  logic       os_tick,
  input  logic       bit_tick,
  input  logic [1:0] char_len,
  input  logic       bypass,
  input  logic       fsk_sel,
  output logic       tx_bit,
  output logic       tx_valid
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_meta, rx_s;
  logic          byp;
  logic          push;
  char_t         push_char;
  char_t         head;
  logic [CW-1:0] count;
  logic          empty;
  logic          pop;
  logic          ser_bit;
  logic          ser_busy;

  assign byp = bypass || fsk_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rx_serial;
      rx_s    <= rx_meta;
    end
  end

  rc_rx_deser #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk(clk), .rst(rst), .clr(byp), .os_tick(os_tick), .rx_s(rx_s),
    .len_sel(char_len), .push(push), .push_char(push_char)
  );

  rc_elastic_fifo #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .clr(byp), .push(push), .wdata(push_char),
    .pop(pop), .rdata(head), .count(count), .empty(empty)
  );

  rc_tx_ser #(.DEPTH(DEPTH), .HIGH_WATER(HIGH_WATER), .DEL_WINDOW(DEL_WINDOW)) u_ser (
    .clk(clk), .rst(rst), .clr(byp), .bit_tick(bit_tick), .empty(empty),
    .count(count), .head(head), .pop(pop), .ser_bit(ser_bit), .busy(ser_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit   <= 1'b1;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= bit_tick;
      if (bit_tick) tx_bit <= byp ? rx_s : ser_bit;
    end
  end

  AST_RESET_MARK: assert property (@(posedge clk)
    $past(rst) |-> (tx_bit && !tx_valid)) else $error("reset state"); // R1
  AST_VALID_TRACKS_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> tx_valid) else $error("missing strobe"); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> (!tx_valid && $stable(tx_bit))) else $error("spurious strobe"); // R2
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !byp && empty && !ser_busy) |=> tx_bit) else $error("idle not mark"); // R3
  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && byp) |=> (tx_bit == $past(rx_s))) else $error("bypass altered"); // R9
endmodule

// File: tb/tb_async_sync_rate_conv.sv
module tb_async_sync_rate_conv;
  localparam int CLK_PERIOD = 10;
  localparam int OS = 16;
  localparam int NVEC = 10;
  // {gap bits[3:0], break, len code[1:0], data[8:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd2, 1'b0, 2'd2, 9'h0A5}, {4'd1, 1'b0, 2'd0, 9'h02A},
    {4'd3, 1'b0, 2'd1, 9'h055}, {4'd0, 1'b0, 2'd3, 9'h1C3},
    {4'd2, 1'b0, 2'd2, 9'h0FF}, {4'd2, 1'b1, 2'd2, 9'h000},
    {4'd1, 1'b0, 2'd2, 9'h000}, {4'd2, 1'b0, 2'd3, 9'h155},
    {4'd2, 1'b0, 2'd0, 9'h03F}, {4'd2, 1'b0, 2'd1, 9'h04C}
  };

  logic clk = 0, rst = 1, rx = 1, os_tick = 1;
  logic man_tick = 0, gen_tick = 0, auto_tick = 0, slow = 0;
  logic [1:0] len_sel = 2'd2;
  logic bypass = 0, fsk = 0;
  logic bit_tick;
  logic tx_bit, tx_valid;
  assign bit_tick = auto_tick ? gen_tick : man_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_sync_rate_conv dut (
    .clk(clk), .rst(rst), .rx_serial(rx), .os_tick(os_tick), .bit_tick(bit_tick),
    .char_len(len_sel), .bypass(bypass), .fsk_sel(fsk), .tx_bit(tx_bit), .tx_valid(tx_valid)
  );

  // output bit-tick generator, optionally about 1% slow
  int gcnt = 0, gnth = 0;
  always @(negedge clk) begin
    if (!auto_tick) begin
      gcnt = 0; gnth = 0; gen_tick <= 0;
    end else begin
      gen_tick <= (gcnt == 0);
      if (gcnt == ((slow && gnth == 5) ? 16 : 15)) begin
        gcnt = 0; gnth = (gnth == 5) ? 0 : gnth + 1;
      end else gcnt = gcnt + 1;
    end
  end

  int n_checks = 0, n_fail = 0;
  logic [8:0] e_data [64];
  logic [1:0] e_len  [64];
  logic       e_brk  [64];
  int e_wr = 0;
  logic parse_en = 0;

  // independent output parser
  int m_checks = 0, m_fail = 0;
  int rd, pstate, pidx, since_del, dels, marks;
  logic [8:0] acc;
  logic last_brk;
  always @(negedge clk) begin
    if (rst) begin
      rd = 0; pstate = 0; pidx = 0; since_del = 7; dels = 0; marks = 0; last_brk = 0; acc = 0;
    end else if (parse_en && tx_valid) begin
      case (pstate)
        0: if (tx_bit) marks++; else begin pstate = 1; pidx = 0; acc = 0; end
        1: begin
          acc[pidx] = tx_bit; pidx++;
          if (pidx == 6 + e_len[rd % 64]) pstate = 2;
        end
        default: begin
          m_checks++;
          if (rd >= e_wr) begin
            m_fail++; $display("FAIL R11: unexpected character, actual index %0d expected below %0d", rd, e_wr);
          end else if (acc != e_data[rd]) begin
            m_fail++; $display("FAIL R4: char %0d data actual %0h expected %0h", rd, acc, e_data[rd]);
          end
          if (rd < e_wr && e_brk[rd]) begin
            m_checks++;
            if (tx_bit) begin
              m_fail++; $display("FAIL R8: break stop bit actual %0d expected 0", tx_bit);
            end
            last_brk = 1; since_del++; pstate = 0;
          end else if (tx_bit) begin
            last_brk = 0; since_del++; pstate = 0;
          end else begin
            dels++;
            m_checks++;
            if (since_del < 7) begin
              m_fail++; $display("FAIL R7: deletion after %0d characters, expected at least 7", since_del);
            end
            m_checks++;
            if (last_brk) begin
              m_fail++; $display("FAIL R8: deletion after break actual 1 expected 0");
            end
            since_del = 0; last_brk = 0; pstate = 1; pidx = 0; acc = 0;
          end
          rd++;
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_bits(input int n);
    repeat (n * OS) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; auto_tick = 0; man_tick = 0;
    repeat (3) @(negedge clk);
    e_wr = 0; rst = 0;
  endtask

  task automatic send_char(input logic [8:0] d, input logic [1:0] lc, input bit brk, input int gap);
    int nd;
    nd = 6 + lc;
    e_data[e_wr] = brk ? 9'h000 : (d & ((9'h1 << nd) - 9'h1));
    e_len[e_wr] = lc; e_brk[e_wr] = brk; e_wr++;
    len_sel = lc;
    if (brk) begin
      rx = 0; wait_bits(2 * (nd + 2));
    end else begin
      rx = 0; wait_bits(1);
      for (int i = 0; i < nd; i++) begin rx = d[i]; wait_bits(1); end
      rx = 1; wait_bits(1);
    end
    rx = 1; wait_bits(gap);
  endtask

  task automatic manual_bit(input logic b, input string req);
    rx = b;
    repeat (4) @(negedge clk);
    man_tick = 1; @(negedge clk); man_tick = 0;
    check(tx_valid === 1'b1, "R2", "strobe after tick", tx_valid, 1);
    check(tx_bit === b, req, "pass-through bit", tx_bit, b);
    @(negedge clk);
    check(tx_valid === 1'b0, "R2", "strobe one cycle only", tx_valid, 0);
  endtask

  initial begin
    logic [11:0] pat;
    pat = 12'b1011_0010_0110;
    // R1 reset state
    rst = 1; repeat (3) @(negedge clk);
    check(tx_bit === 1'b1 && tx_valid === 1'b0, "R1", "reset outputs", {tx_bit, tx_valid}, 2);
    rst = 0; @(negedge clk);
    check(tx_bit === 1'b1 && tx_valid === 1'b0, "R1", "after reset", {tx_bit, tx_valid}, 2);
    // R3 marks while nothing is queued
    for (int i = 0; i < 3; i++) manual_bit(1'b1, "R3");

    // table walk at nominal rate, R4 R5 R3
    do_reset(); parse_en = 1; slow = 0; auto_tick = 1;
    wait_bits(2);
    for (int v = 0; v < NVEC; v++) send_char(VEC[v][8:0], VEC[v][10:9], VEC[v][11], int'(VEC[v][15:12]));
    wait_bits(30);
    check(rd == e_wr, "R4", "characters re-sent at nominal rate", rd, e_wr);
    check(marks > 0, "R3", "inserted mark bits seen", marks > 0, 1);
    check(dels == 0, "R6", "no deletions without backlog", dels, 0);

    // fast terminal: fill the buffer, then run output ~1% slow, R6 R7 R11
    do_reset(); slow = 1;
    send_char(9'h0C3, 2'd2, 0, 0);
    send_char(9'h01E, 2'd2, 0, 0);
    auto_tick = 1;
    for (int i = 2; i < 40; i++) send_char(9'((i * 37 + 11) & 8'hFF), 2'd2, 0, 0);
    wait_bits(40);
    check(rd == e_wr, "R11", "all characters out in order", rd, e_wr);
    check(dels >= 1, "R6", "stop bit deleted under backlog", dels, 1);

    // break followed by queued characters at a full buffer, R8
    do_reset(); slow = 0;
    send_char(9'h000, 2'd2, 1, 2);
    send_char(9'h05A, 2'd2, 0, 0);
    auto_tick = 1;
    send_char(9'h033, 2'd2, 0, 2);
    wait_bits(30);
    check(rd == 3, "R8", "break and followers re-sent", rd, 3);
    check(dels == 0, "R8", "no deletion on or after break", dels, 0);
    parse_en = 0;

    // bypass, R9
    do_reset(); bypass = 1;
    for (int i = 0; i < 12; i++) manual_bit(pat[i], "R9");
    // FSK forces bypass, R10
    bypass = 0; fsk = 1; do_reset();
    for (int i = 0; i < 12; i++) manual_bit(pat[11 - i], "R10");
    fsk = 0;

    $display("[TB] %0d tests run, %0d failed", n_checks + m_checks, n_fail + m_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks + m_checks + 1, n_fail + m_fail + 1);
    $finish;
  end
endmodule